// File: doc/BRIEF.md
# Mixed-Endian Store Data Formatter

This block takes a store request from the register side of a 32-bit datapath and turns it into what a byte-strobed memory write port expects: data placed in the correct byte lanes and one write strobe for each lane. The request carries the register value, the low address bits, an access size and an endianness select. A byte store writes the same way in either ordering. Halfword and word stores place their bytes either least-significant-first (little-endian) or most-significant-first (byte-invariant big-endian) from the addressed byte upward.

A strict-alignment enable makes unaligned halfword and word stores fault. A faulting store drives no write strobe, so memory is left unchanged, and it reports a misaligned fault code. With strict checking off, an unaligned access that runs past the top lane is clipped to the lanes that fit, and a spill flag tells the caller that the remaining bytes must be written to the next word. All outputs are registered, and they appear one clock after the request.

Top module: `store_fmt_lanes`

## Requirements
- R1: While reset is asserted, and one clock after it is released, every output is zero. Otherwise each output reflects the request sampled at the previous rising clock edge.
- R2: A byte store (size code 0) places register bits [7:0] in lane `addr_lo_i` (lane k is data bits [8k+7:8k]) and sets only strobe bit `addr_lo_i`. This holds for both endianness settings.
- R3: A little-endian halfword store (size 1, `big_end_i`=0) places register bits [7:0] in the addressed lane and bits [15:8] in the lane above it.
- R4: A big-endian halfword store (size 1, `big_end_i`=1) places register bits [15:8] in the addressed lane and bits [7:0] in the lane above it.
- R5: A little-endian word store (size 2) at offset 0 places register bits [8k+7:8k] in lane k, with all four strobes set.
- R6: A big-endian word store at offset 0 places register bits [31:24] in lane 0 and bits [7:0] in lane 3.
- R7: Register bits above the access size have no effect on the write data or the strobes of byte and halfword stores.
- R8: Strobe bit k is set exactly when lane k is written. Every lane whose strobe is clear carries zero data.
- R9: With `strict_i`=1, a halfword store with address bit 0 set, or a word store with a nonzero offset, raises `fault_o` with `fault_code_o`=2'b01 (2'b00 when there is no fault). Its strobes and data are zero and `spill_o` is low.
- R10: With `strict_i`=0, an access whose bytes extend past lane 3 writes only the lanes up to lane 3 and raises `spill_o`. Accesses that fit leave `spill_o` low.
- R11: When `st_valid_i` is low, the next cycle shows zero strobes, zero data, no fault and no spill.
- R12: Size code 3 behaves exactly like size code 2 (word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| st_valid_i | input | 1 | Store request present this cycle |
| strict_i | input | 1 | Strict alignment checking enable |
| big_end_i | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| addr_lo_i | input | 2 | Byte offset of the access within the word |
| reg_data_i | input | 32 | Source register value |
| wr_data_o | output | 32 | Lane-steered write data |
| wr_be_o | output | 4 | Per-lane write strobes |
| fault_o | output | 1 | Misaligned access under strict checking |
| fault_code_o | output | 2 | 2'b01 misaligned, 2'b00 none |
| spill_o | output | 1 | Access was clipped at the top lane |

## Verification
The only state in the block is one output register stage. A wrong value held there, or a wrong lane selection feeding it, appears at the ports exactly one clock after the offending request and is gone by the following cycle. The bench therefore compares every output field on every cycle against a model of the byte order in memory. A stale or mis-steered lane, a strobe left set during a fault, or a missing spill flag is reported in the cycle it occurs.

// File: rtl/store_fmt_pkg.sv
package store_fmt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    localparam int FCODE_W = 2;
    localparam logic [FCODE_W-1:0] FC_NONE     = 2'b00;
    localparam logic [FCODE_W-1:0] FC_MISALIGN = 2'b01;

    // number of bytes touched by a given size code (codes 2 and 3 both mean word)
    function automatic int unsigned size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/stfmt_lane_steer.sv
module stfmt_lane_steer #(
    parameter int LANES = 4,
    parameter int OFF_W = 2,
    parameter int CNT_W = 3
) (
    input  logic [LANES*8-1:0] reg_data,
    input  logic [OFF_W-1:0]   offset,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic               big_end,
    output logic [LANES*8-1:0] lane_data,
    output logic [LANES-1:0]   lane_hit
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [CNT_W-1:0] rel;
        logic [CNT_W-1:0] src;
        logic             in_rng;

        always_comb begin
            rel    = CNT_W'(k) - CNT_W'(offset);
            in_rng = (CNT_W'(k) >= CNT_W'(offset)) && (rel < nbytes);
            src    = big_end ? (nbytes - CNT_W'(1) - rel) : rel;
            lane_hit[k]         = in_rng;
            lane_data[k*8 +: 8] = in_rng ? reg_data[src[OFF_W-1:0]*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/stfmt_align_check.sv
module stfmt_align_check #(
    parameter int LANES = 4,
    parameter int OFF_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             valid,
    input  logic             strict,
    input  logic [OFF_W-1:0] offset,
    input  logic [CNT_W-1:0] nbytes,
    output logic             misaligned,
    output logic             spill
);

    logic [CNT_W-1:0] mask;
    logic [CNT_W:0]   reach;

    always_comb begin
        mask       = nbytes - CNT_W'(1);
        misaligned = valid && strict && ((CNT_W'(offset) & mask) != '0);
        reach      = {1'b0, CNT_W'(offset)} + {1'b0, nbytes};
        spill      = valid && !misaligned && (reach > (CNT_W+1)'(LANES));
    end

endmodule

// File: rtl/store_fmt_lanes.sv
module store_fmt_lanes
    import store_fmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      st_valid_i,
    input  logic                      strict_i,
    input  logic                      big_end_i,
    input  logic [1:0]                size_i,
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo_i,
    input  logic [DATA_W-1:0]         reg_data_i,
    output logic [DATA_W-1:0]         wr_data_o,
    output logic [DATA_W/8-1:0]       wr_be_o,
    output logic                      fault_o,
    output logic [FCODE_W-1:0]        fault_code_o,
    output logic                      spill_o
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int CNT_W = OFF_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0]  data;
        logic [LANES-1:0]   be;
        logic               fault;
        logic [FCODE_W-1:0] code;
        logic               spill;
    } wr_out_t;

    wr_out_t out_d, out_q;

    logic [CNT_W-1:0]  nbytes_d;
    logic [DATA_W-1:0] steer_data_d;
    logic [LANES-1:0]  steer_hit_d;
    logic              misal_d;
    logic              spill_d;

    assign nbytes_d = CNT_W'(size_bytes(size_i));

    stfmt_lane_steer #(
        .LANES (LANES),
        .OFF_W (OFF_W),
        .CNT_W (CNT_W)
    ) u_steer (
        .reg_data  (reg_data_i),
        .offset    (addr_lo_i),
        .nbytes    (nbytes_d),
        .big_end   (big_end_i),
        .lane_data (steer_data_d),
        .lane_hit  (steer_hit_d)
    );

    stfmt_align_check #(
        .LANES (LANES),
        .OFF_W (OFF_W),
        .CNT_W (CNT_W)
    ) u_align (
        .valid      (st_valid_i),
        .strict     (strict_i),
        .offset     (addr_lo_i),
        .nbytes     (nbytes_d),
        .misaligned (misal_d),
        .spill      (spill_d)
    );

    always_comb begin
        out_d = '0;
        if (st_valid_i) begin
            if (misal_d) begin
                out_d.fault = 1'b1;
                out_d.code  = FC_MISALIGN;
            end else begin
                out_d.be    = steer_hit_d;
                out_d.data  = steer_data_d;
                out_d.spill = spill_d;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_data_o    = out_q.data;
    assign wr_be_o      = out_q.be;
    assign fault_o      = out_q.fault;
    assign fault_code_o = out_q.code;
    assign spill_o      = out_q.spill;

endmodule

// File: rtl/store_fmt_lanes_chk.sv
module store_fmt_lanes_chk
    import store_fmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        st_valid_i,
    input logic [1:0]                  size_i,
    input logic [DATA_W-1:0]           wr_data_o,
    input logic [DATA_W/8-1:0]         wr_be_o,
    input logic                        fault_o,
    input logic [FCODE_W-1:0]          fault_code_o,
    input logic                        spill_o
);

    localparam int LANES = DATA_W / 8;

    a_r9_fault_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (wr_be_o == '0 && wr_data_o == '0));

    a_r9_code_tracks_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_code_o != FC_NONE) == fault_o);

    a_r10_spill_not_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(spill_o && fault_o));

    a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_valid_i |=> (wr_be_o == '0 && !fault_o && !spill_o));

    a_r2_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_valid_i && size_i == SZ_BYTE) |=> $countones(wr_be_o) == 1);

    a_r3_half_two_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_valid_i && size_i == SZ_HALF) |=> $countones(wr_be_o) <= 2);

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        a_r8_unused_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !wr_be_o[k] |-> wr_data_o[k*8 +: 8] == 8'h00);
    end

endmodule

bind store_fmt_lanes store_fmt_lanes_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_valid_i   (st_valid_i),
    .size_i       (size_i),
    .wr_data_o    (wr_data_o),
    .wr_be_o      (wr_be_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .spill_o      (spill_o)
);

// File: tb/store_fmt_lanes_tb.sv
module store_fmt_lanes_tb;

    logic        clk = 1'b0;
    logic        rst_ni;
    logic        st_valid_i, strict_i, big_end_i;
    logic [1:0]  size_i, addr_lo_i;
    logic [31:0] reg_data_i;
    logic [31:0] wr_data_o;
    logic [3:0]  wr_be_o;
    logic        fault_o, spill_o;
    logic [1:0]  fault_code_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    logic [31:0] e_data;
    logic [3:0]  e_be;
    logic        e_fault, e_spill;
    logic [1:0]  e_code;
    string       e_tag;

    always #2 clk = ~clk;

    store_fmt_lanes u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .st_valid_i(st_valid_i), .strict_i(strict_i),
        .big_end_i(big_end_i), .size_i(size_i), .addr_lo_i(addr_lo_i),
        .reg_data_i(reg_data_i), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
        .fault_o(fault_o), .fault_code_o(fault_code_o), .spill_o(spill_o)
    );

    // behavioural model: list the bytes in memory order, then place each at its address
    task automatic model(input bit v, input bit s, input bit b, input logic [1:0] sz,
                         input logic [1:0] off, input logic [31:0] d);
        byte unsigned mem_bytes[$];
        int n;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        e_data = '0; e_be = '0; e_fault = 0; e_spill = 0; e_code = 2'b00;
        if (!v) return;
        if (s && (int'(off) % n) != 0) begin
            e_fault = 1; e_code = 2'b01;
            return;
        end
        for (int i = 0; i < n; i++)
            mem_bytes.push_back(b ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8]);
        for (int i = 0; i < n; i++) begin
            int addr = int'(off) + i;
            if (addr < 4) begin
                e_data[addr*8 +: 8] = mem_bytes[i];
                e_be[addr] = 1'b1;
            end else begin
                e_spill = 1;
            end
        end
    endtask

    task automatic compare();
        vectors++;
        if (wr_data_o !== e_data || wr_be_o !== e_be || fault_o !== e_fault ||
            fault_code_o !== e_code || spill_o !== e_spill) begin
            misses++;
            $display("FAIL %s: actual data=%h be=%b fault=%b code=%b spill=%b expected data=%h be=%b fault=%b code=%b spill=%b",
                     e_tag, wr_data_o, wr_be_o, fault_o, fault_code_o, spill_o,
                     e_data, e_be, e_fault, e_code, e_spill);
        end
    endtask

    function automatic string auto_tag(input bit v, input bit s, input bit b,
                                       input logic [1:0] sz, input logic [1:0] off);
        if (!v) return "R11";
        if (s && ((sz == 2'd1 && off[0]) || (sz[1] && off != 0))) return "R9";
        if ((sz == 2'd1 && off == 2'd3) || (sz[1] && off != 0)) return "R10";
        if (sz == 2'd0) return "R2";
        if (sz == 2'd1) return b ? "R4" : "R3";
        if (sz == 2'd3) return "R12";
        return b ? "R6" : "R5";
    endfunction

    // check the previous cycle's result, then present a new request
    task automatic apply(input bit v, input bit s, input bit b, input logic [1:0] sz,
                         input logic [1:0] off, input logic [31:0] d, input string tag);
        @(negedge clk);
        compare();
        st_valid_i = v; strict_i = s; big_end_i = b;
        size_i = sz; addr_lo_i = off; reg_data_i = d;
        model(v, s, b, sz, off, d);
        e_tag = (tag == "") ? auto_tag(v, s, b, sz, off) : tag;
    endtask

    initial begin
        rst_ni = 0;
        st_valid_i = 1; strict_i = 0; big_end_i = 0;
        size_i = 2'd2; addr_lo_i = 0; reg_data_i = 32'hDEAD_BEEF;
        e_data = '0; e_be = '0; e_fault = 0; e_spill = 0; e_code = 0; e_tag = "R1";
        repeat (3) begin
            @(negedge clk);
            compare(); // R1: outputs held at zero during reset
        end
        st_valid_i = 0;
        @(negedge clk);
        rst_ni = 1;
        e_tag = "R1";
        // R2: byte at every offset, both orders
        for (int o = 0; o < 4; o++) begin
            apply(1, 0, 0, 2'd0, 2'(o), 32'hA1B2C3D4, "R2");
            apply(1, 1, 1, 2'd0, 2'(o), 32'h11223344, "R2");
        end
        apply(1, 0, 0, 2'd1, 2'd0, 32'h0000BEEF, "R3");
        apply(1, 1, 0, 2'd1, 2'd2, 32'h0000CAFE, "R3");
        apply(1, 0, 1, 2'd1, 2'd0, 32'h0000BEEF, "R4");
        apply(1, 1, 1, 2'd1, 2'd2, 32'h0000CAFE, "R4");
        apply(1, 1, 0, 2'd2, 2'd0, 32'h01234567, "R5");
        apply(1, 1, 1, 2'd2, 2'd0, 32'h01234567, "R6");
        // R7: upper bits vary, lanes must match the clean values
        apply(1, 0, 0, 2'd0, 2'd1, 32'hFFFFFF5A, "R7");
        apply(1, 0, 1, 2'd1, 2'd2, 32'h9876A55A, "R7");
        apply(1, 0, 0, 2'd1, 2'd1, 32'h0000C3E1, "R8");
        apply(1, 1, 0, 2'd1, 2'd1, 32'h12345678, "R9");
        apply(1, 1, 1, 2'd2, 2'd2, 32'h12345678, "R9");
        apply(1, 1, 0, 2'd3, 2'd3, 32'h12345678, "R9");
        apply(1, 0, 0, 2'd1, 2'd3, 32'h0000ABCD, "R10");
        apply(1, 0, 1, 2'd1, 2'd3, 32'h0000ABCD, "R10");
        apply(1, 0, 1, 2'd2, 2'd1, 32'hA0B0C0D0, "R10");
        apply(1, 0, 0, 2'd2, 2'd2, 32'hA0B0C0D0, "R10");
        apply(0, 1, 0, 2'd2, 2'd1, 32'hFFFFFFFF, "R11");
        apply(1, 0, 1, 2'd3, 2'd0, 32'h89ABCDEF, "R12");
        apply(1, 0, 0, 2'd3, 2'd2, 32'h89ABCDEF, "R12");
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            apply(r[0] | r[1], r[2], r[3], r[5:4], r[7:6], $urandom, "");
        end
        apply(0, 0, 0, 2'd0, 2'd0, 32'h0, "R11");
        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            misses++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule